// File: doc/BRIEF.md
# Object Centroid Histogram Imager

This block turns an unordered list of detected objects into a raster image. Each object arrives as a pair of coordinate sums plus an area. The block divides each sum by the area to get the object's centre of gravity. It clamps each coordinate to the image range and increments one bin of an internal count memory. The bin address puts the row (Y) in the upper bits and the column (X) in the lower bits. Objects may arrive in any order; the finished image does not depend on that order.

When the object flagged as last has been counted, the block streams the whole count memory out. It starts at the top-left bin and runs left to right, then row by row. Each count is one pixel, and the stream carries start/end-of-line and start/end-of-frame markers. After the final pixel is accepted, every bin is cleared, and then the block accepts the next list.

The object input and the pixel output are valid/ready streams. An object is taken in the cycle where `obj_valid` and `obj_ready` are both high; the sender must hold its fields stable until then. `obj_ready` is low while the memory is being cleared, while an object is still being divided, and during the whole readout. A pixel is taken in the cycle where `pix_valid` and `pix_ready` are both high. While `pix_ready` is low, the pixel and its markers are held unchanged. The side of the image is 2**COORD_W (32 by default, at most 256).

Top module: `cl2h_top`

## Requirements
- R1: After reset, and after each final pixel is accepted, the block clears all 2**(2*COORD_W) bins over exactly that many cycles with `obj_ready` and `pix_valid` low; each list therefore counts from zero.
- R2: Only one object is in flight: in the cycle after an object is accepted, `obj_ready` is low, and it stays low until that object's bin has been incremented.
- R3: Each coordinate equals floor(sum / area). A quotient above 2**COORD_W-1, or an area of 0, gives the value 2**COORD_W-1.
- R4: The bin address is {Y, X}, with Y the upper COORD_W bits. An object with coordinates (X, Y) appears in row Y at column X of the output image.
- R5: A bin count saturates at 2**CNT_W-1 (15 by default) instead of wrapping.
- R6: An object with `obj_last` high ends the list; once its bin is updated, readout begins. No object is accepted during readout, even with `obj_valid` held high, and such an offered object has no effect on any image.
- R7: Readout emits exactly 2**(2*COORD_W) pixels: row 0 first, each row with X ascending, and each pixel equal to its bin count.
- R8: `pix_sol` is high on X=0, `pix_eol` on X=2**COORD_W-1, `pix_sof` on the first pixel of the frame and `pix_eof` on the last one.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid`, `pix_count` and all four markers hold their values; the pixel advances only on a handshake.
- R10: The image depends only on the multiset of objects in the list, not on the order in which they arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| obj_valid | input | 1 | Object offered |
| obj_ready | output | 1 | Block can accept an object |
| obj_sum_x | input | SUM_W | Sum of X over the object's pixels |
| obj_sum_y | input | SUM_W | Sum of Y over the object's pixels |
| obj_area | input | AREA_W | Pixel count of the object |
| obj_last | input | 1 | Final object of the list |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Receiver accepts the pixel |
| pix_count | output | CNT_W | Bin count shown as pixel value |
| pix_sol | output | 1 | First pixel of a line |
| pix_eol | output | 1 | Last pixel of a line |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
The bound checker watches the stream rules on every cycle. It checks that only one object is in flight, that no object is accepted while pixels are offered, and that a stalled pixel and its markers stay steady. It also checks that the frame markers imply the line markers, that a new line follows each accepted line end, and that clearing begins after the final pixel. Only the bench scenarios can show the arithmetic and the image contents. These cover division and clamping (including a zero area), the row/column placement, saturation, order independence, clearing between lists, and the clear-phase length. They also show that an object offered during readout leaves no trace in any image.

// File: rtl/cl2h_pkg.sv
package cl2h_pkg;

  typedef enum logic [1:0] {
    PH_CLEAR   = 2'd0,
    PH_COLLECT = 2'd1,
    PH_DIVIDE  = 2'd2,
    PH_READOUT = 2'd3
  } phase_t;

endpackage

// File: rtl/cl2h_divider.sv
// Restoring divider, one quotient bit per cycle, N_W cycles per division.
// A zero divisor gives an all-ones quotient.
module cl2h_divider #(
  parameter int N_W = 16,
  parameter int D_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] num,
  input  logic [D_W-1:0] den,
  output logic           done,
  output logic [N_W-1:0] quo
);
  localparam int STEP_W = $clog2(N_W + 1);

  logic [N_W-1:0]    shreg;
  logic [D_W-1:0]    rem;
  logic [D_W-1:0]    den_r;
  logic [STEP_W-1:0] steps_left;
  logic              running;

  logic [D_W:0] trial;
  logic         fits;
  logic [D_W:0] diff;

  always_comb begin
    trial = {rem, shreg[N_W-1]};
    fits  = trial >= {1'b0, den_r};
    diff  = trial - {1'b0, den_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      rem        <= '0;
      den_r      <= '0;
      steps_left <= '0;
      running    <= 1'b0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shreg      <= num;
        rem        <= '0;
        den_r      <= den;
        steps_left <= STEP_W'(N_W);
        running    <= 1'b1;
      end else if (running) begin
        shreg      <= {shreg[N_W-2:0], fits};
        rem        <= fits ? diff[D_W-1:0] : trial[D_W-1:0];
        steps_left <= steps_left - 1'b1;
        if (steps_left == STEP_W'(1)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end
      end
    end
  end

  assign quo = shreg;

endmodule

// File: rtl/cl2h_bins.sv
// Count memory: one clear port, one saturating increment port, one read port.
module cl2h_bins #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] clr_addr,
  input  logic              inc_en,
  input  logic [ADDR_W-1:0] inc_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data
);
  localparam int NBINS = 2 ** ADDR_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] mem [NBINS];
  logic [CNT_W-1:0] inc_old;

  assign inc_old = mem[inc_addr];
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (clr_en) begin
      mem[clr_addr] <= '0;
    end else if (inc_en && (inc_old != CNT_MAX)) begin
      mem[inc_addr] <= inc_old + 1'b1;
    end
  end

endmodule

// File: rtl/cl2h_raster.sv
// Scan-order address generator for readout, with line and frame markers.
module cl2h_raster #(
  parameter int COORD_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 pix_ready,
  output logic                 pix_valid,
  output logic [2*COORD_W-1:0] addr,
  output logic                 sol,
  output logic                 eol,
  output logic                 sof,
  output logic                 eof,
  output logic                 frame_done
);
  localparam int ADDR_W = 2 * COORD_W;

  logic [COORD_W-1:0] col;
  logic               take;

  assign col        = addr[COORD_W-1:0];
  assign pix_valid  = run;
  assign take       = run && pix_ready;
  assign sol        = run && (col == '0);
  assign eol        = run && (col == '1);
  assign sof        = run && (addr == '0);
  assign eof        = run && (addr == '1);
  assign frame_done = take && (addr == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (take) begin
      addr <= addr + ADDR_W'(1);
    end
  end

endmodule

// File: rtl/cl2h_top.sv
module cl2h_top #(
  parameter int COORD_W = 5,
  parameter int SUM_W   = 16,
  parameter int AREA_W  = 8,
  parameter int CNT_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obj_valid,
  output logic              obj_ready,
  input  logic [SUM_W-1:0]  obj_sum_x,
  input  logic [SUM_W-1:0]  obj_sum_y,
  input  logic [AREA_W-1:0] obj_area,
  input  logic              obj_last,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [CNT_W-1:0]  pix_count,
  output logic              pix_sol,
  output logic              pix_eol,
  output logic              pix_sof,
  output logic              pix_eof
);
  import cl2h_pkg::*;

  localparam int ADDR_W = 2 * COORD_W;
  localparam int unsigned CMAX = (2 ** COORD_W) - 1;

  phase_t            phase;
  logic [ADDR_W-1:0] clr_addr;
  logic              last_r;

  logic              take_obj;
  logic [1:0]        div_done;
  logic [SUM_W-1:0]  div_num [2];
  logic [SUM_W-1:0]  div_quo [2];
  logic [COORD_W-1:0] coord [2];
  logic              all_done;

  logic              inc_en;
  logic [ADDR_W-1:0] inc_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic              frame_done;

  assign obj_ready = (phase == PH_COLLECT);
  assign take_obj  = obj_valid && obj_ready;
  assign div_num[0] = obj_sum_x;
  assign div_num[1] = obj_sum_y;

  // axis 0 is X, axis 1 is Y
  for (genvar g = 0; g < 2; g++) begin : g_axis
    cl2h_divider #(.N_W(SUM_W), .D_W(AREA_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .start(take_obj),
      .num  (div_num[g]),
      .den  (obj_area),
      .done (div_done[g]),
      .quo  (div_quo[g])
    );
    assign coord[g] = (div_quo[g] > SUM_W'(CMAX)) ? COORD_W'(CMAX)
                                                   : div_quo[g][COORD_W-1:0];
  end

  assign all_done = &div_done;
  assign inc_en   = (phase == PH_DIVIDE) && all_done;
  assign inc_addr = {coord[1], coord[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CLEAR;
      clr_addr <= '0;
      last_r   <= 1'b0;
    end else begin
      unique case (phase)
        PH_CLEAR: begin
          clr_addr <= clr_addr + ADDR_W'(1);
          if (clr_addr == '1) phase <= PH_COLLECT;
        end
        PH_COLLECT: begin
          if (take_obj) begin
            last_r <= obj_last;
            phase  <= PH_DIVIDE;
          end
        end
        PH_DIVIDE: begin
          if (all_done) phase <= last_r ? PH_READOUT : PH_COLLECT;
        end
        PH_READOUT: begin
          if (frame_done) phase <= PH_CLEAR;
        end
        default: phase <= PH_CLEAR;
      endcase
    end
  end

  cl2h_bins #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bins (
    .clk     (clk),
    .clr_en  (phase == PH_CLEAR),
    .clr_addr(clr_addr),
    .inc_en  (inc_en),
    .inc_addr(inc_addr),
    .rd_addr (rd_addr),
    .rd_data (pix_count)
  );

  cl2h_raster #(.COORD_W(COORD_W)) u_raster (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (phase == PH_READOUT),
    .pix_ready (pix_ready),
    .pix_valid (pix_valid),
    .addr      (rd_addr),
    .sol       (pix_sol),
    .eol       (pix_eol),
    .sof       (pix_sof),
    .eof       (pix_eof),
    .frame_done(frame_done)
  );

endmodule

// File: rtl/cl2h_checker.sv
module cl2h_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             obj_valid,
  input logic             obj_ready,
  input logic             pix_valid,
  input logic             pix_ready,
  input logic [CNT_W-1:0] pix_count,
  input logic             pix_sol,
  input logic             pix_eol,
  input logic             pix_sof,
  input logic             pix_eof
);

  assert_one_in_flight_R2: assert property (@(posedge clk) disable iff (!rst_n)
    obj_valid && obj_ready |=> !obj_ready);

  assert_no_accept_in_readout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !obj_ready);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_count)
      && $stable({pix_sol, pix_eol, pix_sof, pix_eof}));

  assert_sof_on_line_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_sof |-> pix_sol);

  assert_eof_on_line_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_eof |-> pix_eol);

  assert_next_line_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_eol && !pix_eof |=> pix_valid && pix_sol);

  assert_clear_after_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && pix_eof |=> !obj_ready && !pix_valid);

endmodule

bind cl2h_top cl2h_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .obj_valid(obj_valid),
  .obj_ready(obj_ready),
  .pix_valid(pix_valid),
  .pix_ready(pix_ready),
  .pix_count(pix_count),
  .pix_sol  (pix_sol),
  .pix_eol  (pix_eol),
  .pix_sof  (pix_sof),
  .pix_eof  (pix_eof)
);

// File: tb/sim_cl2h_top.sv
module sim_cl2h_top;
  localparam int CLK_PERIOD = 10;
  localparam int COORD_W = 5;
  localparam int SUM_W   = 16;
  localparam int AREA_W  = 8;
  localparam int CNT_W   = 4;
  localparam int SIDE    = 2 ** COORD_W;
  localparam int NBINS   = SIDE * SIDE;
  localparam int CMAX    = SIDE - 1;
  localparam int KMAX    = (2 ** CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic obj_valid = 1'b0;
  logic obj_ready;
  logic [SUM_W-1:0] obj_sum_x = '0;
  logic [SUM_W-1:0] obj_sum_y = '0;
  logic [AREA_W-1:0] obj_area = '0;
  logic obj_last = 1'b0;
  logic pix_valid;
  logic pix_ready = 1'b0;
  logic [CNT_W-1:0] pix_count;
  logic pix_sol, pix_eol, pix_sof, pix_eof;

  int checks = 0;
  int errors = 0;
  int model [NBINS];
  int got [NBINS];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cl2h_top #(.COORD_W(COORD_W), .SUM_W(SUM_W), .AREA_W(AREA_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .obj_valid(obj_valid), .obj_ready(obj_ready),
    .obj_sum_x(obj_sum_x), .obj_sum_y(obj_sum_y),
    .obj_area(obj_area), .obj_last(obj_last),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_count(pix_count),
    .pix_sol(pix_sol), .pix_eol(pix_eol), .pix_sof(pix_sof), .pix_eof(pix_eof)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int coord_of(input int s, input int a);
    int q;
    if (a == 0) return CMAX;
    q = s / a;
    return (q > CMAX) ? CMAX : q;
  endfunction

  function automatic int bin_of(input int x, input int y);
    return y * SIDE + x;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NBINS; i++) model[i] = 0;
  endtask

  // Offer one object, wait for its handshake, check R2 and update the model.
  task automatic send_obj(input int sx, input int sy, input int a, input bit last);
    int b;
    int wait_n = 0;
    @(negedge clk);
    obj_valid = 1'b1;
    obj_sum_x = SUM_W'(sx);
    obj_sum_y = SUM_W'(sy);
    obj_area  = AREA_W'(a);
    obj_last  = last;
    while (!obj_ready && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    @(posedge clk);
    @(negedge clk);
    obj_valid = 1'b0;
    obj_last  = 1'b0;
    check(!obj_ready, "R2 ready low after accept", int'(obj_ready), 0);
    b = bin_of(coord_of(sx, a), coord_of(sy, a));
    if (model[b] < KMAX) model[b]++;
  endtask

  // Drain one frame; stall selects back-pressure, junk offers an object throughout.
  task automatic collect(input bit stall, input bit junk, input string tag);
    int idx = 0;
    int wait_n = 0;
    int mk_err = 0;
    int hold_err = 0;
    int rdy_err = 0;
    int mism = 0;
    bit prev_stall = 1'b0;
    logic [CNT_W-1:0] prev_cnt = '0;
    logic [3:0] prev_mk = '0;
    if (junk) begin
      obj_valid = 1'b1;
      obj_sum_x = SUM_W'(9);
      obj_sum_y = SUM_W'(9);
      obj_area  = AREA_W'(3);
      obj_last  = 1'b1;
    end
    while (idx < NBINS && wait_n < 20000) begin
      @(negedge clk);
      if (junk && pix_valid && obj_ready) rdy_err++;
      if (prev_stall && (!pix_valid || pix_count != prev_cnt ||
          {pix_sol, pix_eol, pix_sof, pix_eof} != prev_mk)) hold_err++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_ready = stall ? (lfsr[0] | lfsr[5]) : 1'b1;
      prev_stall = 1'b0;
      if (pix_valid) begin
        if (pix_ready) begin
          got[idx] = int'(pix_count);
          if (pix_sol != (idx % SIDE == 0) || pix_eol != (idx % SIDE == SIDE-1) ||
              pix_sof != (idx == 0) || pix_eof != (idx == NBINS-1)) mk_err++;
          idx++;
        end else begin
          prev_stall = 1'b1;
          prev_cnt = pix_count;
          prev_mk = {pix_sol, pix_eol, pix_sof, pix_eof};
        end
      end else begin
        wait_n++;
      end
    end
    @(negedge clk);
    pix_ready = 1'b0;
    obj_valid = 1'b0;
    obj_last  = 1'b0;
    check(idx == NBINS, {"R7 pixel count ", tag}, idx, NBINS);
    check(!pix_valid, {"R7 no extra pixel ", tag}, int'(pix_valid), 0);
    check(mk_err == 0, {"R8 markers ", tag}, mk_err, 0);
    if (stall) check(hold_err == 0, {"R9 hold on stall ", tag}, hold_err, 0);
    if (junk) check(rdy_err == 0, {"R6 ready during readout ", tag}, rdy_err, 0);
    for (int i = 0; i < NBINS; i++) begin
      if (got[i] != model[i]) begin
        mism++;
        if (mism <= 4)
          $display("FAIL R7 %s bin %0d: actual %0d expected %0d", tag, i, got[i], model[i]);
      end
    end
    check(mism == 0, {"R7 image ", tag}, mism, 0);
  endtask

  task automatic t_reset();
    int n = 0;
    check(!obj_ready && !pix_valid, "R1 reset state", int'({obj_ready, pix_valid}), 0);
    while (!obj_ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
    check(n == NBINS, "R1 clear length", n, NBINS);
  endtask

  task automatic send_list_a(input bit reversed);
    if (!reversed) begin
      send_obj(100, 50, 10, 0);
      send_obj(1000, 20, 4, 0);
      send_obj(7, 9, 0, 0);
      send_obj(0, 0, 255, 0);
      send_obj(65535, 310, 255, 0);
      send_obj(104, 59, 10, 1);
    end else begin
      send_obj(104, 59, 10, 0);
      send_obj(65535, 310, 255, 0);
      send_obj(0, 0, 255, 0);
      send_obj(7, 9, 0, 0);
      send_obj(1000, 20, 4, 0);
      send_obj(100, 50, 10, 1);
    end
  endtask

  task automatic t_basic();
    model_clear();
    send_list_a(1'b0);
    collect(1'b0, 1'b0, "basic");
    check(got[bin_of(10, 5)] == 2, "R3 floor division (10,5)", got[bin_of(10, 5)], 2);
    check(got[bin_of(5, 10)] == 0, "R4 row/column not swapped", got[bin_of(5, 10)], 0);
    check(got[bin_of(31, 5)] == 1, "R3 clamp X", got[bin_of(31, 5)], 1);
    check(got[bin_of(31, 31)] == 1, "R3 zero area", got[bin_of(31, 31)], 1);
    check(got[bin_of(31, 1)] == 1, "R3 clamp wide sum", got[bin_of(31, 1)], 1);
    check(got[bin_of(0, 0)] == 1, "R4 top-left bin", got[bin_of(0, 0)], 1);
  endtask

  task automatic t_reorder();
    model_clear();
    send_list_a(1'b1);
    collect(1'b0, 1'b0, "reordered");
    check(got[bin_of(10, 5)] == 2, "R10 same bin after reorder", got[bin_of(10, 5)], 2);
    check(got[bin_of(0, 0)] == 1, "R1 previous list cleared", got[bin_of(0, 0)], 1);
  endtask

  task automatic t_saturate();
    model_clear();
    for (int i = 0; i < 20; i++) send_obj(60, 90, 3, i == 19);
    collect(1'b1, 1'b0, "saturate");
    check(got[bin_of(20, 30)] == KMAX, "R5 saturation", got[bin_of(20, 30)], KMAX);
  endtask

  task automatic t_ignore_in_readout();
    model_clear();
    send_obj(31, 62, 31, 1);
    collect(1'b1, 1'b1, "junk offered");
    check(got[bin_of(3, 3)] == 0, "R6 offered object not counted", got[bin_of(3, 3)], 0);
    model_clear();
    send_obj(40, 8, 2, 1);
    collect(1'b0, 1'b0, "after junk");
    check(got[bin_of(3, 3)] == 0, "R6 no late effect", got[bin_of(3, 3)], 0);
    check(got[bin_of(1, 2)] == 0, "R1 cleared after junk frame", got[bin_of(1, 2)], 0);
    check(got[bin_of(20, 4)] == 1, "R4 placement", got[bin_of(20, 4)], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_reorder();
    t_saturate();
    t_ignore_in_readout();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule